// File: doc/BRIEF.md
# Programmable Half-Period Timing Pulse Generator

This block produces a slow periodic timing signal, nominally one second, from one of up to sixteen reference sources. Each source is modelled as a one-cycle enable strobe in the single system clock domain. The user programs a half-period count. The output level inverts after that many ticks of the chosen source, so a full period lasts twice the programmed count and the duty cycle is exactly 50%. For example, a 155.52 MHz reference needs a count of 77,760,000 to give a one-second period.

A second mode hands the output to software. A processor writes the desired level into a register, and the output follows that register. In this mode the output stays at the written level for as long as needed. No regular writes are required and no duty cycle is imposed.

Top module: `sec_pulse_gen`

## Requirements
- R1: While reset is active and on the first cycle after it, `pulse_out` is 0, the block is in counter mode, and the stored count is zero.
- R2: Only the strobe at index `src_sel` of `src_tick` advances the counter. Strobes on the other indices leave `pulse_out` unchanged.
- R3: With a nonzero count N in counter mode, `pulse_out` inverts on the Nth selected tick after the previous inversion or reload, giving high and low phases of N ticks each.
- R4: A cycle with `count_wr`=1 stores `count_data` and restarts the tick count from zero. If the new value is nonzero, the output level is kept, and the next inversion comes N selected ticks after the write.
- R5: A stored count of zero forces the counter-mode output to 0 and stops counting. A zero write drives the output low on the clock edge that stores it.
- R6: When `sw_wr`=1, `sw_data` is stored at the clock edge. In software mode, `pulse_out` equals that stored value from the following cycle on.
- R7: `sw_mode` (1 = software, 0 = counter) is registered, so a change appears at `pulse_out` one clock edge later. The counter keeps running while software mode is active.
- R8: In software mode, with no `sw_wr`, `pulse_out` holds its level indefinitely, whatever happens on the ticks or the count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| src_tick | input | NUM_SRC | One-cycle enable strobe per reference source |
| src_sel | input | SEL_W | Index of the reference source that drives the counter |
| count_wr | input | 1 | Write strobe for the half-period count |
| count_data | input | CNT_W | Half-period count in selected ticks (0 = stopped) |
| sw_mode | input | 1 | 1 = software-driven output, 0 = counter output |
| sw_wr | input | 1 | Write strobe for the software level |
| sw_data | input | 1 | Software output level |
| pulse_out | output | 1 | Timing pulse output |

## Verification
The counter is driven in three ways. A selected tick on every cycle shows the exact half-period length. Pseudo-random strobes on all sources, with the selection moved between them, show that unselected sources have no effect. Isolated single ticks around a count rewrite show that the count restarts but the level is kept. The software path is tested with writes made in counter mode, then by switching modes while the two levels differ. Each mode switch must be seen one edge later, and the software level must hold steady through long bursts of ticks.

// File: rtl/sec_pulse_pkg.sv
package sec_pulse_pkg;
    parameter int CNT_W = 32;
    typedef logic [CNT_W-1:0] cnt_t;

    typedef struct packed {
        cnt_t ticks;
        cnt_t limit;
        logic level;
    } core_state_t;

    typedef struct packed {
        logic sw_sel;
        logic sw_level;
    } ctl_state_t;
endpackage

// File: rtl/sec_tick_select.sv
module sec_tick_select #(
    parameter int NUM_SRC = 16,
    parameter int SEL_W   = 4
) (
    input  logic [NUM_SRC-1:0] src_tick,
    input  logic [SEL_W-1:0]   src_sel,
    output logic               tick
);
    logic [NUM_SRC-1:0] hit;

    for (genvar i = 0; i < NUM_SRC; i++) begin : g_hit
        assign hit[i] = src_tick[i] && (src_sel == SEL_W'(i));
    end

    assign tick = |hit;
endmodule

// File: rtl/sec_halfperiod_core.sv
module sec_halfperiod_core
    import sec_pulse_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic tick,
    input  logic load,
    input  cnt_t load_val,
    output logic level
);
    core_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (load) begin
            st_d.limit = load_val;
            st_d.ticks = '0;
            if (load_val == '0) st_d.level = 1'b0;
        end else if (st_q.limit == '0) begin
            st_d.ticks = '0;
            st_d.level = 1'b0;
        end else if (tick) begin
            if (st_q.ticks == st_q.limit - 1'b1) begin
                st_d.ticks = '0;
                st_d.level = ~st_q.level;
            end else begin
                st_d.ticks = st_q.ticks + 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign level = st_q.level;
endmodule

// File: rtl/sec_pulse_gen.sv
module sec_pulse_gen
    import sec_pulse_pkg::*;
#(
    parameter int NUM_SRC = 16,
    localparam int SEL_W  = (NUM_SRC > 1) ? $clog2(NUM_SRC) : 1
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [NUM_SRC-1:0] src_tick,
    input  logic [SEL_W-1:0]   src_sel,
    input  logic               count_wr,
    input  logic [CNT_W-1:0]   count_data,
    input  logic               sw_mode,
    input  logic               sw_wr,
    input  logic               sw_data,
    output logic               pulse_out
);
    logic       sel_tick;
    logic       hw_level;
    ctl_state_t ctl_d, ctl_q;

    sec_tick_select #(.NUM_SRC(NUM_SRC), .SEL_W(SEL_W)) i_sel (
        .src_tick (src_tick),
        .src_sel  (src_sel),
        .tick     (sel_tick)
    );

    sec_halfperiod_core i_core (
        .clk      (clk),
        .rst_n    (rst_n),
        .tick     (sel_tick),
        .load     (count_wr),
        .load_val (count_data),
        .level    (hw_level)
    );

    always_comb begin
        ctl_d        = ctl_q;
        ctl_d.sw_sel = sw_mode;
        if (sw_wr) ctl_d.sw_level = sw_data;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) ctl_q <= '0;
        else        ctl_q <= ctl_d;
    end

    assign pulse_out = ctl_q.sw_sel ? ctl_q.sw_level : hw_level;
endmodule

// File: rtl/sec_pulse_gen_chk.sv
module sec_pulse_gen_chk
    import sec_pulse_pkg::*;
#(
    parameter int NUM_SRC = 16,
    localparam int SEL_W  = (NUM_SRC > 1) ? $clog2(NUM_SRC) : 1
) (
    input logic               clk,
    input logic               rst_n,
    input logic [NUM_SRC-1:0] src_tick,
    input logic [SEL_W-1:0]   src_sel,
    input logic               count_wr,
    input logic [CNT_W-1:0]   count_data,
    input logic               sw_mode,
    input logic               sw_wr,
    input logic               sw_data,
    input logic               pulse_out
);
    p_zero_low_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (count_wr && count_data == '0 && !sw_mode) |=> !pulse_out);

    p_sw_follow_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (sw_mode && sw_wr) |=> (pulse_out == $past(sw_data)));

    p_sw_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (sw_mode && $past(sw_mode) && !sw_wr) |=> $stable(pulse_out));

    p_no_sel_tick_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (!sw_mode && !$past(sw_mode) && !src_tick[src_sel] && !count_wr)
        |=> $stable(pulse_out));
endmodule

bind sec_pulse_gen sec_pulse_gen_chk #(.NUM_SRC(NUM_SRC)) i_chk (.*);

// File: tb/test_sec_pulse_gen.sv
module test_sec_pulse_gen;
    localparam int NS = 16;
    localparam int SW = 4;
    localparam int CW = 32;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [NS-1:0] src_tick = '0;
    logic [SW-1:0] src_sel = '0;
    logic          count_wr = 1'b0;
    logic [CW-1:0] count_data = '0;
    logic          sw_mode = 1'b0;
    logic          sw_wr = 1'b0;
    logic          sw_data = 1'b0;
    logic          pulse_out;

    int checks = 0;
    int fails  = 0;
    int cyc    = 0;
    string cur_req = "R1";

    longint ref_cnt = 0, ref_lim = 0;
    bit ref_hw = 0, ref_sw = 0, ref_mode = 0;
    bit model_on = 0;

    always #5 clk = ~clk;

    sec_pulse_gen #(.NUM_SRC(NS)) i_sec_pulse_gen (.*);

    task automatic check(input string req, input logic act, input logic exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: pulse_out=%0b expected %0b (cycle %0d)", req, act, exp, cyc);
        end
    endtask

    task automatic check_int(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s: got %0d expected %0d (cycle %0d)", req, act, exp, cyc);
        end
    endtask

    // behavioural reference model, advanced on every edge
    always @(posedge clk) begin
        cyc++;
        if (!rst_n) begin
            ref_cnt = 0; ref_lim = 0; ref_hw = 0; ref_sw = 0; ref_mode = 0;
        end else begin
            ref_mode = sw_mode;
            if (sw_wr) ref_sw = sw_data;
            if (count_wr) begin
                ref_lim = count_data;
                ref_cnt = 0;
                if (count_data == 0) ref_hw = 0;
            end else if (ref_lim == 0) begin
                ref_hw = 0;
                ref_cnt = 0;
            end else if (src_tick[src_sel]) begin
                ref_cnt++;
                if (ref_cnt == ref_lim) begin
                    ref_cnt = 0;
                    ref_hw = !ref_hw;
                end
            end
        end
        if (cyc > 100000) begin
            checks++; fails++;
            $display("FAIL watchdog: run did not finish, got %0d cycles expected < 100000", cyc);
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

    always @(negedge clk)
        if (model_on) check({cur_req, " model"}, pulse_out, ref_mode ? ref_sw : ref_hw);

    task automatic step(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic write_count(input int v);
        count_wr = 1'b1; count_data = v;
        step(1);
        count_wr = 1'b0;
    endtask

    task automatic one_tick(input int idx);
        src_tick = '0; src_tick[idx] = 1'b1;
        step(1);
        src_tick = '0;
        step(1);
    endtask

    initial begin
        logic lvl;
        int run;
        logic [15:0] lfsr = 16'hACE1;

        step(3);
        check("R1", pulse_out, 1'b0);
        rst_n = 1'b1;
        step(1);
        check("R1", pulse_out, 1'b0);
        model_on = 1;

        // R3: ticks every cycle, count 3
        cur_req = "R3";
        src_sel = 4'd2;
        write_count(3);
        src_tick = 16'h0004;
        while (!pulse_out) step(1);
        run = 0;
        while (pulse_out && run < 50) begin run++; step(1); end
        check_int("R3 high run", run, 3);
        run = 0;
        while (!pulse_out && run < 50) begin run++; step(1); end
        check_int("R3 low run", run, 3);

        // R2: random strobes on all sources, several selections
        cur_req = "R2";
        for (int k = 0; k < 300; k++) begin
            lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
            src_tick = lfsr;
            if (k % 60 == 0) src_sel = SW'(k / 60 * 3);
            step(1);
        end
        src_sel = 4'd7;
        src_tick = 16'hFF7F;
        lvl = pulse_out;
        step(20);
        check("R2 unselected", pulse_out, lvl);
        src_tick = '0;

        // R4: rewrite restarts the count, keeps the level
        cur_req = "R4";
        write_count(4);
        lvl = pulse_out;
        one_tick(7); one_tick(7);
        write_count(4);
        check("R4 level kept", pulse_out, lvl);
        one_tick(7); one_tick(7); one_tick(7);
        check("R4 no early toggle", pulse_out, lvl);
        one_tick(7);
        check("R4 toggle after N", pulse_out, !lvl);

        // R5: zero count forces low and stops
        cur_req = "R5";
        if (!pulse_out) begin one_tick(7); one_tick(7); one_tick(7); one_tick(7); end
        check("R5 precondition high", pulse_out, 1'b1);
        write_count(0);
        check("R5 zero forces low", pulse_out, 1'b0);
        src_tick = 16'hFFFF;
        step(30);
        check("R5 stays low", pulse_out, 1'b0);
        src_tick = '0;

        // R6/R7: store level in counter mode, then switch
        cur_req = "R6";
        sw_wr = 1'b1; sw_data = 1'b1;
        step(1);
        sw_wr = 1'b0;
        check("R6 not visible in counter mode", pulse_out, 1'b0);
        cur_req = "R7";
        sw_mode = 1'b1;
        check("R7 before edge", pulse_out, 1'b0);
        step(1);
        check("R7 after edge", pulse_out, 1'b1);
        cur_req = "R6";
        sw_wr = 1'b1; sw_data = 1'b0;
        step(1);
        sw_wr = 1'b0;
        check("R6 follows write", pulse_out, 1'b0);

        // R8: hold with no writes while counter runs underneath
        cur_req = "R8";
        sw_wr = 1'b1; sw_data = 1'b1;
        step(1);
        sw_wr = 1'b0;
        write_count(2);
        src_tick = 16'h0080;
        step(200);
        check("R8 held", pulse_out, 1'b1);

        // R7: back to counter mode, counter kept running
        cur_req = "R7";
        sw_mode = 1'b0;
        step(1);
        check("R7 back to counter", pulse_out, ref_hw);
        step(10);
        src_tick = '0;

        // R1: reset mid-run
        cur_req = "R1";
        rst_n = 1'b0;
        step(2);
        check("R1 reset clears", pulse_out, 1'b0);
        rst_n = 1'b1;
        src_tick = 16'hFFFF;
        step(10);
        check("R1 count zero after reset", pulse_out, 1'b0);
        src_tick = '0;

        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule